// File: doc/BRIEF.md
# AGC Event Timing Sequencer

This block paces the receive gain-control loop for a single packet. A start pulse from packet detection opens a sequence. A sample counter then advances once per valid input sample. Nine one-cycle strobes are raised at programmed sample counts: two RSSI captures, a voltage-in-dB capture, DC-offset start, DC-filter enable, AGC done, and reset strobes for the receive high-pass filter, the RF gain and the baseband gain. Each event time is an unsigned 8-bit count measured from the start of the sequence. The times are packed into three 32-bit configuration words, and the block copies those words at the moment the sequence starts.

The controller has three named states. IDLE waits for a start. RUN counts samples and fires events. DONE holds the finished flag. Its transitions are as follows. IDLE goes to RUN on start. RUN goes to DONE on the valid sample whose count equals the done time. DONE goes to RUN on a new start. Soft clear takes any state to IDLE and wins over a start in the same cycle. A start seen in RUN is not a transition, and the sequence carries on. Typical settings are 8 and 24 for the RSSI captures, 48 for the voltage capture, 60 for DC-offset start, 93 for filter enable and 95 for done. Typical reset times are 0 for the high-pass reset, 30 for the RF gain reset and 25 for the baseband gain reset.

Top module: `agc_event_seq`

## Requirements
- R1: After reset, all strobes, `busy` and `done_flag` are low.
- R2: A `start` seen in IDLE or DONE begins a sequence. `busy` is high in the next cycle and the sample count restarts at 0.
- R3: The count advances only on cycles where `smp_valid` is high, and no strobe follows a cycle with `smp_valid` low.
- R4: Each event bit of `evt_stb` pulses for exactly one cycle, one cycle after the valid sample whose index (counted from 0) equals its time. The bit map is: 0 RSSI capture 1, 1 RSSI capture 2, 2 voltage-dB capture, 3 DC-offset start, 4 DC-filter enable, 5 done, 6 high-pass reset, 7 RF gain reset, 8 baseband gain reset.
- R5: `cfg_main` carries RSSI capture 1 in bits 7:0, RSSI capture 2 in 15:8, voltage-dB capture in 23:16 and done in 31:24.
- R6: `cfg_dco` carries DC-offset start in bits 7:0 and filter enable in 15:8. `cfg_rst` carries the high-pass reset in 7:0, the RF gain reset in 15:8 and the baseband gain reset in 23:16. All other bits are unused.
- R7: The done event ends the sequence. `busy` falls, `done_flag` is high from the done strobe onward until the next start or soft clear, and any event whose time exceeds the done time never fires.
- R8: A `start` while `busy` is high is ignored, so no event fires twice.
- R9: Changing the configuration words during a sequence has no effect on that sequence.
- R10: `soft_clr` returns the block to IDLE in the next cycle, with `busy` and `done_flag` low and no further strobes. It wins over a simultaneous `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| soft_clr | input | 1 | Abandon the sequence and go idle |
| start | input | 1 | Packet-detect start pulse |
| smp_valid | input | 1 | Input sample valid; the count advances on it |
| cfg_main | input | 32 | RSSI, voltage-dB and done times |
| cfg_dco | input | 32 | DC-offset start and filter-enable times |
| cfg_rst | input | 32 | Reset-event times |
| evt_stb | output | 9 | One-cycle event strobes, bit map as in R4 |
| busy | output | 1 | Sequence running |
| done_flag | output | 1 | Sequence finished |

## Verification
The table drives several configurations, each under one of three valid cadences: every cycle, every second cycle and every third cycle. Because the cadence changes the wall-clock time but not the sample index, a counter that also ran on idle cycles would fail under the slower cadences. The configurations cover the typical times, ties between events, events of time zero, events placed after the done time, a done time of 0 and a done time of 255. Together these separate correct field decoding from wrong slots and correct cut-off at done from late firing. Some runs also pulse a second start and rewrite the words mid-sequence, which exposes any restart or live reading of the configuration. Directed cases cover a sequence starved of valid samples and soft clear, both alone and alongside a start.

// File: rtl/agc_seq_pkg.sv
package agc_seq_pkg;

    localparam int NEV = 9;

    // event indices, equal to bit positions of evt_stb
    localparam int EV_RSSI1 = 0;
    localparam int EV_RSSI2 = 1;
    localparam int EV_VDB   = 2;
    localparam int EV_DCO   = 3;
    localparam int EV_FILT  = 4;
    localparam int EV_DONE  = 5;
    localparam int EV_HPF   = 6;
    localparam int EV_RFG   = 7;
    localparam int EV_BBG   = 8;

    // source word (0 main, 1 dco, 2 rst) and field slot of each event
    localparam int EV_WORD [NEV] = '{0, 0, 0, 1, 1, 0, 2, 2, 2};
    localparam int EV_SLOT [NEV] = '{0, 1, 2, 0, 1, 3, 0, 1, 2};

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/agc_cfg_latch.sv
module agc_cfg_latch
    import agc_seq_pkg::*;
#(
    parameter int TW = 8,
    parameter int RW = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [RW-1:0]          cfg_main,
    input  logic [RW-1:0]          cfg_dco,
    input  logic [RW-1:0]          cfg_rst,
    output logic [NEV-1:0][TW-1:0] times
);

    logic [NEV-1:0][TW-1:0] field;

    for (genvar i = 0; i < NEV; i++) begin : g_field
        localparam int LSB = EV_SLOT[i] * TW;
        if (EV_WORD[i] == 0) begin : g_main
            assign field[i] = cfg_main[LSB +: TW];
        end else if (EV_WORD[i] == 1) begin : g_dco
            assign field[i] = cfg_dco[LSB +: TW];
        end else begin : g_rst
            assign field[i] = cfg_rst[LSB +: TW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    times <= '0;
        else if (load) times <= field;
    end

    p_times_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(times));

endmodule

// File: rtl/agc_seq_fsm.sv
module agc_seq_fsm
    import agc_seq_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          start,
    input  logic          smp_valid,
    input  logic [TW-1:0] done_time,
    output logic [TW-1:0] cnt,
    output logic          load,
    output logic          fire,
    output logic          busy,
    output logic          done_flag
);

    seq_state_e state, nxt;
    logic       at_done;

    assign at_done = (cnt == done_time);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (!soft_clr && start)                nxt = ST_RUN;
            ST_RUN:  if (soft_clr)                          nxt = ST_IDLE;
                     else if (smp_valid && at_done)         nxt = ST_DONE;
            ST_DONE: if (soft_clr)                          nxt = ST_IDLE;
                     else if (start)                        nxt = ST_RUN;
            default:                                        nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state == ST_RUN);
        done_flag = (state == ST_DONE);
        load      = !soft_clr && start && (state != ST_RUN);
        fire      = (state == ST_RUN) && smp_valid && !soft_clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= '0;
        else if (fire && !at_done)  cnt <= cnt + 1'b1;
    end

    p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) && !smp_valid && !soft_clr |=> cnt == $past(cnt));
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) && start && !soft_clr && !(smp_valid && at_done)
        |=> state == ST_RUN);
    p_clr_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> state == ST_IDLE);
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> cnt <= done_time);

endmodule

// File: rtl/agc_event_cmp.sv
module agc_event_cmp
    import agc_seq_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fire,
    input  logic [TW-1:0]          cnt,
    input  logic [NEV-1:0][TW-1:0] times,
    output logic [NEV-1:0]         stb
);

    for (genvar i = 0; i < NEV; i++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n) stb[i] <= 1'b0;
            else        stb[i] <= fire && (cnt == times[i]);
        end
    end

    p_stb_after_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|stb) |-> $past(fire));

endmodule

// File: rtl/agc_event_seq.sv
module agc_event_seq
    import agc_seq_pkg::*;
#(
    parameter int TW = 8,
    parameter int RW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           soft_clr,
    input  logic           start,
    input  logic           smp_valid,
    input  logic [RW-1:0]  cfg_main,
    input  logic [RW-1:0]  cfg_dco,
    input  logic [RW-1:0]  cfg_rst,
    output logic [NEV-1:0] evt_stb,
    output logic           busy,
    output logic           done_flag
);

    logic [NEV-1:0][TW-1:0] times;
    logic [TW-1:0]          cnt;
    logic                   load;
    logic                   fire;

    agc_cfg_latch #(.TW(TW), .RW(RW)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .cfg_main (cfg_main),
        .cfg_dco  (cfg_dco),
        .cfg_rst  (cfg_rst),
        .times    (times)
    );

    agc_seq_fsm #(.TW(TW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .start     (start),
        .smp_valid (smp_valid),
        .done_time (times[EV_DONE]),
        .cnt       (cnt),
        .load      (load),
        .fire      (fire),
        .busy      (busy),
        .done_flag (done_flag)
    );

    agc_event_cmp #(.TW(TW)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .cnt   (cnt),
        .times (times),
        .stb   (evt_stb)
    );

    p_done_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stb[EV_DONE] |-> done_flag && !busy);
    p_done_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> evt_stb[EV_DONE]);

endmodule

// File: tb/agc_event_seq_test.sv
module agc_event_seq_test;

    localparam int NEV = 9;
    localparam int NV  = 6;

    typedef struct packed {
        logic [31:0] main;
        logic [31:0] dco;
        logic [31:0] rst;
        logic [1:0]  mode;
        logic        disturb;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{32'h5F30_1808, 32'h0000_5D3C, 32'h0019_1E00, 2'd0, 1'b0},
        '{32'h5F30_1808, 32'h0000_5D3C, 32'h0019_1E00, 2'd1, 1'b0},
        '{32'h1400_0303, 32'h0000_1514, 32'h00C8_1300, 2'd2, 1'b0},
        '{32'hFF80_01FE, 32'h0000_FF00, 32'h0040_7F10, 2'd0, 1'b1},
        '{32'h0005_0700, 32'h0000_0000, 32'h0000_0100, 2'd1, 1'b1},
        '{32'h5F30_1808, 32'h0000_5D3C, 32'h0019_1E00, 2'd2, 1'b1}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           soft_clr = 1'b0;
    logic           start = 1'b0;
    logic           smp_valid = 1'b0;
    logic [31:0]    cfg_main = '0;
    logic [31:0]    cfg_dco = '0;
    logic [31:0]    cfg_rst = '0;
    logic [NEV-1:0] evt_stb;
    logic           busy;
    logic           done_flag;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5ns clk = ~clk;

    agc_event_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .start     (start),
        .smp_valid (smp_valid),
        .cfg_main  (cfg_main),
        .cfg_dco   (cfg_dco),
        .cfg_rst   (cfg_rst),
        .evt_stb   (evt_stb),
        .busy      (busy),
        .done_flag (done_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // field positions per R5 and R6, bit map per R4
    function automatic int ev_time(input vec_t v, input int e);
        case (e)
            0: return int'(v.main[7:0]);
            1: return int'(v.main[15:8]);
            2: return int'(v.main[23:16]);
            3: return int'(v.dco[7:0]);
            4: return int'(v.dco[15:8]);
            5: return int'(v.main[31:24]);
            6: return int'(v.rst[7:0]);
            7: return int'(v.rst[15:8]);
            default: return int'(v.rst[23:16]);
        endcase
    endfunction

    task automatic run_vec(input vec_t v);
        int pos [NEV];
        int hits [NEV];
        int nvalid = 0;
        int cyc = 0;
        bit last_v = 0;
        bit seen_done = 0;
        int idle_stb = 0;
        for (int e = 0; e < NEV; e++) begin
            pos[e] = -1;
            hits[e] = 0;
        end
        @(negedge clk);
        cfg_main = v.main; cfg_dco = v.dco; cfg_rst = v.rst;
        start = 1'b1; smp_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", int'(busy), 1);
        while (!seen_done && cyc < 1500) begin
            if (evt_stb != '0 && !last_v) idle_stb++;
            for (int e = 0; e < NEV; e++) begin
                if (evt_stb[e]) begin
                    hits[e]++;
                    if (pos[e] < 0) pos[e] = nvalid - 1;
                end
            end
            if (done_flag) seen_done = 1;
            start = 1'b0;
            if (v.disturb && nvalid == 3 && cyc < 20) begin
                start = 1'b1;
                cfg_main = ~v.main; cfg_dco = ~v.dco; cfg_rst = ~v.rst;
            end
            case (v.mode)
                2'd0:    last_v = 1;
                2'd1:    last_v = (cyc % 2 == 0);
                default: last_v = (cyc % 3 == 0);
            endcase
            smp_valid = seen_done ? 1'b0 : last_v;
            if (smp_valid) nvalid++;
            cyc++;
            @(negedge clk);
        end
        start = 1'b0; smp_valid = 1'b0;
        check("R7 busy low at end", int'(busy), 0);
        check("R7 done_flag held", int'(done_flag), 1);
        check("R3 no strobe after idle sample", idle_stb, 0);
        for (int e = 0; e < NEV; e++) begin
            int t = ev_time(v, e);
            int d = ev_time(v, 5);
            int exp_pos = (t <= d) ? t : -1;
            check($sformatf("R4/R5/R6/R9 event %0d position", e), pos[e], exp_pos);
            check($sformatf("R4/R7/R8 event %0d pulse count", e), hits[e], (exp_pos >= 0) ? 1 : 0);
        end
    endtask

    initial begin
        #(200000 * 5ns);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int stray;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 strobes after reset", int'(evt_stb), 0);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 done after reset", int'(done_flag), 0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R3: a sequence starved of valid samples fires nothing
        cfg_main = 32'h5F30_1808; cfg_dco = 32'h0000_5D3C; cfg_rst = 32'h0019_1E00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        stray = 0;
        repeat (60) begin
            @(negedge clk);
            if (evt_stb != '0) stray++;
        end
        check("R3 no strobes without valid", stray, 0);
        check("R3 still busy without valid", int'(busy), 1);

        // R10: soft clear mid-run
        smp_valid = 1'b1;
        repeat (20) @(negedge clk);
        soft_clr = 1'b1;
        @(negedge clk);
        soft_clr = 1'b0;
        check("R10 busy after clear", int'(busy), 0);
        check("R10 done after clear", int'(done_flag), 0);
        stray = 0;
        repeat (150) begin
            @(negedge clk);
            if (evt_stb != '0) stray++;
        end
        check("R10 no strobes after clear", stray, 0);
        check("R10 done stays low", int'(done_flag), 0);

        // R10: clear wins over start
        soft_clr = 1'b1; start = 1'b1;
        @(negedge clk);
        soft_clr = 1'b0; start = 1'b0;
        check("R10 clear beats start", int'(busy), 0);
        smp_valid = 1'b0;
        @(negedge clk);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule